// File: doc/BRIEF.md
# Page-Size-Aware Translation Lookup Array

This block is the tag half of a small, fully associative address-translation cache. Each entry holds a virtual page number, a two-bit page-size code and a valid flag. A lookup compares an incoming virtual page number against every entry in parallel.

The stored size code decides how much of the key takes part in the compare. A base-size page must match on every key bit. A large page compares only the upper segment, so that one entry covers every address whose lower segment falls inside it. The array reports whether any entry hit, the index of the winning entry (lowest index first) and that entry's size code. The companion data store, the choice of replacement slot and permission checks sit outside this block.

Entries are loaded one at a time through a binary write index. A flush input empties the whole array: it suppresses hits in the cycle it is raised and clears all valid flags at the next clock edge.

Top module: `xlate_cam_array`

## Requirements
- R1: While `rst_n` is low at a rising edge, every entry becomes invalid, so after reset no lookup key produces `hit`.
- R2: An entry is written at a rising edge only when `wr_en` is high and `wr_idx` equals its index. With `wr_en` low nothing changes, and the other entries keep their contents.
- R3: An entry written with size code 2'b00 (base page) hits only when all `KEY_W` bits of `look_vpn` equal its stored key. A difference in any single bit is a miss.
- R4: An entry written with size code 2'b01 (large page) hits for every value of the lower `KEY_W-HI_W` key bits, provided the upper `HI_W` bits equal the stored ones. A difference in the upper bits is a miss.
- R5: An entry written with size code 2'b10 or 2'b11 never hits.
- R6: On a hit, `hit_idx` gives the index of the winning entry and `hit_size` gives the size code stored in that entry.
- R7: When several entries match, the lowest index wins.
- R8: While `flush` is high, `hit` is low in that same cycle, whatever the contents.
- R9: A rising edge with `flush` high invalidates every entry. This includes an entry being written in the same cycle, because flush takes priority over a write.
- R10: A write takes effect at the rising edge. A lookup in the same cycle as the write sees the old contents, and the new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| look_vpn | input | KEY_W | Virtual page number to look up |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Binary index of the entry to write |
| wr_vpn | input | KEY_W | Virtual page number to store |
| wr_size | input | 2 | Page-size code to store (00 base, 01 large, others unused) |
| flush | input | 1 | Invalidate all entries; suppress hits this cycle |
| hit | output | 1 | Some valid entry matches and no flush is active |
| hit_idx | output | IDX_W | Lowest matching entry index (meaningful when `hit`) |
| hit_size | output | 2 | Size code of the entry at `hit_idx` |

## Verification
The assertions take the lookup and write inputs to be known, non-X values whenever reset is released. They also assume that `flush` and `wr_en` may coincide; that case is legal and is covered by the flush-priority property. The bench drives every input on the falling edge and keeps `wr_en` low outside deliberate write cycles. Reset is held for several edges before any property is enabled. Duplicate keys are created on purpose, so the lowest-index property is exercised rather than only assumed.

// File: rtl/xlate_pkg.sv
// Shared types for the translation lookup array.
// Assumes: size codes other than base and large are never meant to match.
package xlate_pkg;
    typedef enum logic [1:0] {
        PG_BASE  = 2'b00,
        PG_LARGE = 2'b01,
        PG_RSV2  = 2'b10,
        PG_RSV3  = 2'b11
    } pg_size_e;
endpackage

// File: rtl/xlate_onehot_dec.sv
// Binary-to-one-hot line select, qualified by an enable.
// Assumes: idx is below 2**IDX_W (always true for an IDX_W-bit value).
module xlate_onehot_dec #(
    parameter int IDX_W = 3,
    localparam int N    = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    output logic [N-1:0]     lines
);
    // Decode one line per index position.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/xlate_prio_enc.sv
// Lowest-index-first priority encoder over a request vector.
// Assumes: the caller qualifies idx with its own "any request" flag.
module xlate_prio_enc #(
    parameter int IDX_W = 3,
    localparam int N    = 1 << IDX_W
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlate_cam_entry.sv
// One lookup entry: stores key, size code and valid; compares with a
// size-dependent mask. Assumes flush has priority over a write.
module xlate_cam_entry
    import xlate_pkg::*;
#(
    parameter int KEY_W = 20,
    parameter int HI_W  = 10,
    localparam int LO_W = KEY_W - HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_wr,
    input  logic             flush,
    input  logic [KEY_W-1:0] wr_vpn,
    input  logic [1:0]       wr_size,
    input  logic [KEY_W-1:0] look_vpn,
    output logic             match,
    output logic [1:0]       size_out
);
    logic             valid_q;
    logic [KEY_W-1:0] key_q;
    pg_size_e         size_q;
    logic             cmp;

    // State update: reset, then flush, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            key_q   <= '0;
            size_q  <= PG_BASE;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (line_wr) begin
            valid_q <= 1'b1;
            key_q   <= wr_vpn;
            size_q  <= pg_size_e'(wr_size);
        end
    end

    // Size-dependent compare: full key for base, upper segment for large.
    always_comb begin
        case (size_q)
            PG_BASE:  cmp = (key_q == look_vpn);
            PG_LARGE: cmp = (key_q[KEY_W-1:LO_W] == look_vpn[KEY_W-1:LO_W]);
            default:  cmp = 1'b0;
        endcase
    end

    assign match    = valid_q && cmp;
    assign size_out = size_q;

    // R2: a qualified write without flush loads the entry.
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr && !flush) |=> (valid_q && key_q == $past(wr_vpn)
                                 && size_out == $past(wr_size)));

    // R9: flush empties the entry at the next edge.
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid_q);

    // R5: unused size codes never produce a match.
    p_rsv_nomatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_out[1]) |-> !match);
endmodule

// File: rtl/xlate_cam_array.sv
// Array of 2**IDX_W lookup entries with write decode and priority select.
// Assumes: hit_idx and hit_size are only meaningful while hit is high.
module xlate_cam_array #(
    parameter int IDX_W = 3,
    parameter int KEY_W = 20,
    parameter int HI_W  = 10,
    localparam int N    = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] look_vpn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_vpn,
    input  logic [1:0]       wr_size,
    input  logic             flush,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [1:0]       hit_size
);
    logic [N-1:0] wr_lines;
    logic [N-1:0] match_vec;
    logic [1:0]   size_arr [N];

    xlate_onehot_dec #(.IDX_W(IDX_W)) u_dec (
        .idx   (wr_idx),
        .en    (wr_en),
        .lines (wr_lines)
    );

    for (genvar i = 0; i < N; i++) begin : g_ent
        xlate_cam_entry #(.KEY_W(KEY_W), .HI_W(HI_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_wr  (wr_lines[i]),
            .flush    (flush),
            .wr_vpn   (wr_vpn),
            .wr_size  (wr_size),
            .look_vpn (look_vpn),
            .match    (match_vec[i]),
            .size_out (size_arr[i])
        );
    end

    xlate_prio_enc #(.IDX_W(IDX_W)) u_pri (
        .req (match_vec),
        .idx (hit_idx)
    );

    assign hit      = (|match_vec) && !flush;
    assign hit_size = size_arr[hit_idx];

    // R8: no hit is reported during a flush cycle.
    p_flush_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !hit);

    // R6: the reported index really matches.
    p_idx_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);

    // R7: no lower-indexed entry matches when a hit is reported.
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & ((N'(1) << hit_idx) - N'(1))) == '0));

    // R2: at most one entry is selected for writing.
    p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_lines));
endmodule

// File: tb/xlate_cam_array_tb.sv
module xlate_cam_array_tb;
    localparam int IDX_W = 3;
    localparam int KEY_W = 20;
    localparam int HI_W  = 10;
    localparam int LO_W  = KEY_W - HI_W;
    localparam int N     = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [KEY_W-1:0] look_vpn = '0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [KEY_W-1:0] wr_vpn = '0;
    logic [1:0]       wr_size = '0;
    logic             flush = 1'b0;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [1:0]       hit_size;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected contents, maintained from the requirements.
    bit               m_valid [N];
    logic [KEY_W-1:0] m_key   [N];
    logic [1:0]       m_size  [N];

    always #2 clk = ~clk;

    xlate_cam_array #(.IDX_W(IDX_W), .KEY_W(KEY_W), .HI_W(HI_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .look_vpn(look_vpn), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_size(wr_size), .flush(flush),
        .hit(hit), .hit_idx(hit_idx), .hit_size(hit_size)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_idx(input logic [KEY_W-1:0] v);
        for (int i = 0; i < N; i++) begin
            if (m_valid[i]) begin
                if (m_size[i] == 2'b00 && m_key[i] == v) return i;
                if (m_size[i] == 2'b01 && m_key[i][KEY_W-1:LO_W] == v[KEY_W-1:LO_W]) return i;
            end
        end
        return -1;
    endfunction

    // Compare outputs with the model; called after inputs settle mid-cycle.
    task automatic cmp_now(input string req, input bit flushing);
        int e;
        e = flushing ? -1 : model_idx(look_vpn);
        chk(hit == (e >= 0), req, "hit", int'(hit), int'(e >= 0));
        if (e >= 0 && hit) begin
            chk(hit_idx == IDX_W'(e), req, "hit_idx", int'(hit_idx), e);
            chk(hit_size == m_size[e], req, "hit_size", int'(hit_size), int'(m_size[e]));
        end
    endtask

    task automatic look(input logic [KEY_W-1:0] v, input string req);
        @(negedge clk);
        look_vpn = v;
        #1;
        cmp_now(req, 1'b0);
    endtask

    task automatic wr(input int idx, input logic [KEY_W-1:0] v, input logic [1:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = v; wr_size = s;
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[idx] = 1'b1; m_key[idx] = v; m_size[idx] = s;
    endtask

    task automatic clear_model();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    endtask

    initial begin
        clear_model();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(20'h00000, "R1");
        look(20'h12345, "R1");
        look(20'hFFFFF, "R1");

        // R3: base page exact match only, every single-bit difference misses
        wr(2, 20'h12345, 2'b00);
        look(20'h12345, "R3");
        for (int b = 0; b < KEY_W; b++) look(20'h12345 ^ (20'h1 << b), "R3");

        // R4: large page covers the whole lower segment
        wr(5, {10'h2AB, 10'h0F0}, 2'b01);
        for (int lo = 0; lo < (1 << LO_W); lo++) look({10'h2AB, LO_W'(lo)}, "R4");
        for (int b = 0; b < HI_W; b++) look({10'h2AB ^ (10'h1 << b), 10'h0F0}, "R4");

        // R5: unused size codes never hit
        wr(6, 20'hABCDE, 2'b10);
        wr(7, 20'h55555, 2'b11);
        look(20'hABCDE, "R5");
        look(20'h55555, "R5");

        // R6, R7: duplicates resolve to lowest index, size reported
        wr(3, {10'h2AB, 10'h001}, 2'b00);
        look({10'h2AB, 10'h001}, "R7");
        wr(1, {10'h2AB, 10'h3FF}, 2'b01);
        look({10'h2AB, 10'h001}, "R7");
        look({10'h2AB, 10'h3FF}, "R6");
        look(20'h12345, "R6");

        // R2: no write when wr_en is low; other entries untouched
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd0; wr_vpn = 20'h77777; wr_size = 2'b00;
        @(negedge clk);
        look(20'h77777, "R2");
        wr(0, 20'h77777, 2'b00);
        look(20'h77777, "R2");
        look(20'h12345, "R2");
        look({10'h2AB, 10'h155}, "R2");

        // R10: lookup in the write cycle sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd4; wr_vpn = 20'h0BEEF; wr_size = 2'b00;
        look_vpn = 20'h0BEEF;
        #1;
        cmp_now("R10", 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[4] = 1'b1; m_key[4] = 20'h0BEEF; m_size[4] = 2'b00;
        #1;
        cmp_now("R10", 1'b0);

        // R8: flush forces hit low in its own cycle
        @(negedge clk);
        look_vpn = 20'h12345;
        flush = 1'b1;
        #1;
        cmp_now("R8", 1'b1);
        @(negedge clk);
        flush = 1'b0;
        clear_model();

        // R9: everything gone after the flush edge
        look(20'h12345, "R9");
        look(20'h0BEEF, "R9");
        look({10'h2AB, 10'h000}, "R9");

        // R9: flush beats a simultaneous write
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd0; wr_vpn = 20'h31415; wr_size = 2'b00;
        flush = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; flush = 1'b0;
        look(20'h31415, "R9");

        // R1: reset after writes empties the array
        wr(2, 20'h27182, 2'b00);
        wr(6, {10'h111, 10'h000}, 2'b01);
        look(20'h27182, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        look(20'h27182, "R1");
        look({10'h111, 10'h2A2}, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule